// File: doc/BRIEF.md
# Alternating Block Stream Splitter

The splitter takes one wide 512-bit data stream, organised as 4 KB blocks of 64 beats, and spreads it over two narrower 256-bit output streams. Whole blocks alternate between the two sides. The first block after reset and every even-numbered block after it go to side 0. Every odd-numbered block goes to side 1. Each side has a private buffer with room for four blocks. Each side replays its blocks as 128 half-width beats and has its own valid/ready handshake, so a stall on one side never holds up the other.

The input side is credit-based at block granularity. A side grants room for a block only while it has a free block slot. The input waits for the side whose turn it is and never jumps ahead to the other one. A side raises its output valid only after a block has been written into it completely. A slot is returned after the last of that block's 128 output beats has been accepted. Reset empties both buffers and points the turn at side 0.

Top module: `block_pair_splitter`

## Requirements
- R1: After reset, both output valids are low, the input ready is high, and the first accepted block goes to side 0.
- R2: A block is 64 accepted input beats. Blocks counted from reset go to side 0 when their index is even and to side 1 when it is odd.
- R3: Each accepted 512-bit word leaves its side as two 256-bit beats, bits 255:0 first and then bits 511:256. Words leave in the order they were accepted.
- R4: A side's output valid is low until at least one complete 64-beat block has been written into that side.
- R5: A side holds at most four blocks. While the side whose turn it is holds four unreleased blocks, the input ready is low, even if the other side has room.
- R6: A side's block slot is released one cycle after the 128th output beat of that block is accepted. If that side is next in turn, the input ready rises then.
- R7: Each output stream advances independently: a stalled output on one side does not stop the other side from draining.
- R8: While a side's output valid is high and its ready is low, the valid stays high and the data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Input word can be taken |
| in_data | input | 512 | Input word |
| out0_valid | output | 1 | Side 0 beat is valid |
| out0_ready | input | 1 | Side 0 consumer takes the beat |
| out0_data | output | 256 | Side 0 beat |
| out1_valid | output | 1 | Side 1 beat is valid |
| out1_ready | input | 1 | Side 1 consumer takes the beat |
| out1_data | output | 256 | Side 1 beat |

## Verification
Some properties are checked on every cycle. A write is never allowed into a side that already holds four blocks. The turn can change only at a block boundary, and it holds while the input is stalled. An output valid is only ever high while its side counts a stored block. A stalled output beat stays unchanged. Other behaviour can only be shown by the bench scenarios. These include the half-word order, and the 64-beat point at which an output first becomes valid. They also include the refusal to skip to the other side when the next side is full, and the exact beat that returns a slot. The bench provokes each of these by holding the outputs stalled, draining one side alone, and then running both sides with random readiness.

// File: rtl/blk_split_pkg.sv
package blk_split_pkg;

  typedef enum logic {
    SIDE_EVEN = 1'b0,
    SIDE_ODD  = 1'b1
  } side_e;

  function automatic int words_per_block(input int block_bytes, input int word_bits);
    return (block_bytes * 8) / word_bits;
  endfunction

endpackage

// File: rtl/blk_steer.sv
module blk_steer
  import blk_split_pkg::*;
#(
  parameter int IN_W        = 512,
  parameter int BLOCK_BYTES = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] space,
  output logic [1:0] wr_en,
  output logic       wr_last
);

  localparam int BEATS = words_per_block(BLOCK_BYTES, IN_W);
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] BEAT_LAST = BW'(BEATS - 1);

  side_e         turn;
  logic [BW-1:0] beat_cnt;
  logic          fire;

  assign in_ready = space[turn];
  assign fire     = in_valid && in_ready;
  assign wr_last  = (beat_cnt == BEAT_LAST);
  assign wr_en    = fire ? ((turn == SIDE_ODD) ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      turn     <= SIDE_EVEN;
      beat_cnt <= '0;
    end else if (fire) begin
      if (wr_last) begin
        beat_cnt <= '0;
        turn     <= (turn == SIDE_EVEN) ? SIDE_ODD : SIDE_EVEN;
      end else begin
        beat_cnt <= beat_cnt + 1'b1;
      end
    end
  end

  AST_TURN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (beat_cnt != '0) |-> $stable(turn)); // R2

  AST_STALL_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> (turn == $past(turn))); // R5

endmodule

// File: rtl/blk_bank.sv
module blk_bank
  import blk_split_pkg::*;
#(
  parameter int IN_W        = 512,
  parameter int OUT_W       = 256,
  parameter int BLOCK_BYTES = 4096,
  parameter int SLOTS       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_last,
  input  logic [IN_W-1:0]  wr_data,
  output logic             space,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  localparam int RATIO = IN_W / OUT_W;
  localparam int SW    = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int WORDS = words_per_block(BLOCK_BYTES, IN_W);
  localparam int DEPTH = SLOTS * WORDS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int UW    = $clog2(SLOTS + 1);
  localparam int FW    = $clog2(DEPTH + 1);
  localparam int OBEAT = WORDS * RATIO;
  localparam int OW    = (OBEAT > 1) ? $clog2(OBEAT) : 1;

  localparam logic [SW-1:0] SEL_LAST  = SW'(RATIO - 1);
  localparam logic [OW-1:0] OUT_LAST  = OW'(OBEAT - 1);
  localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);
  localparam logic [UW-1:0] SLOT_CAP  = UW'(SLOTS);
  localparam logic [FW-1:0] BLK_WORDS = FW'(WORDS);

  logic [IN_W-1:0] mem [DEPTH];
  logic [IN_W-1:0] hold_data;
  logic            hold_valid;
  logic [SW-1:0]   sel;
  logic [AW-1:0]   wr_ptr;
  logic [AW-1:0]   rd_ptr;
  logic [UW-1:0]   used;
  logic [FW-1:0]   fetch_cnt;
  logic [OW-1:0]   out_cnt;
  logic            out_fire;
  logic            last_sel;
  logic            can_fetch;
  logic            blk_done;
  logic            slot_free;
  logic [OUT_W-1:0] lanes [RATIO];

  assign space     = (used < SLOT_CAP);
  assign out_valid = hold_valid;
  assign out_fire  = hold_valid && out_ready;
  assign last_sel  = (sel == SEL_LAST);
  assign blk_done  = wr_en && wr_last;
  assign slot_free = out_fire && (out_cnt == OUT_LAST);
  assign can_fetch = (fetch_cnt != '0) && (!hold_valid || (out_fire && last_sel));

  genvar li;
  generate
    for (li = 0; li < RATIO; li++) begin : g_lane
      assign lanes[li] = hold_data[li*OUT_W +: OUT_W];
    end
  endgenerate

  assign out_data = lanes[sel];

  // Storage: written and read without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    if (can_fetch) hold_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == ADDR_LAST) ? '0 : wr_ptr + 1'b1;
      if (can_fetch) rd_ptr <= (rd_ptr == ADDR_LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  // Slot credits: a slot is counted from block completion to its last output beat
  always_ff @(posedge clk) begin
    if (rst) begin
      used <= '0;
    end else begin
      case ({blk_done, slot_free})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

  // Words of completed blocks not yet moved into the output register
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_cnt <= '0;
    end else begin
      fetch_cnt <= fetch_cnt + (blk_done ? BLK_WORDS : '0) - (can_fetch ? FW'(1) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      sel        <= '0;
    end else if (can_fetch) begin
      hold_valid <= 1'b1;
      sel        <= '0;
    end else if (out_fire) begin
      if (last_sel) hold_valid <= 1'b0;
      else          sel <= sel + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_cnt <= '0;
    end else if (out_fire) begin
      out_cnt <= (out_cnt == OUT_LAST) ? '0 : out_cnt + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (used < SLOT_CAP)); // R5

  AST_VALID_NEEDS_BLOCK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (used != '0)); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

endmodule

// File: rtl/block_pair_splitter.sv
module block_pair_splitter
  import blk_split_pkg::*;
#(
  parameter int IN_W        = 512,
  parameter int OUT_W       = 256,
  parameter int BLOCK_BYTES = 4096,
  parameter int SLOTS       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out0_valid,
  input  logic             out0_ready,
  output logic [OUT_W-1:0] out0_data,
  output logic             out1_valid,
  input  logic             out1_ready,
  output logic [OUT_W-1:0] out1_data
);

  localparam int SIDES = 2;

  logic [SIDES-1:0] space;
  logic [SIDES-1:0] wr_en;
  logic             wr_last;
  logic [SIDES-1:0] o_valid;
  logic [SIDES-1:0] o_ready;
  logic [OUT_W-1:0] o_data [SIDES];

  blk_steer #(
    .IN_W        (IN_W),
    .BLOCK_BYTES (BLOCK_BYTES)
  ) u_steer (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .space    (space),
    .wr_en    (wr_en),
    .wr_last  (wr_last)
  );

  genvar s;
  generate
    for (s = 0; s < SIDES; s++) begin : g_side
      blk_bank #(
        .IN_W        (IN_W),
        .OUT_W       (OUT_W),
        .BLOCK_BYTES (BLOCK_BYTES),
        .SLOTS       (SLOTS)
      ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en[s]),
        .wr_last   (wr_last),
        .wr_data   (in_data),
        .space     (space[s]),
        .out_valid (o_valid[s]),
        .out_ready (o_ready[s]),
        .out_data  (o_data[s])
      );
    end
  endgenerate

  assign o_ready    = {out1_ready, out0_ready};
  assign out0_valid = o_valid[0];
  assign out1_valid = o_valid[1];
  assign out0_data  = o_data[0];
  assign out1_data  = o_data[1];

endmodule

// File: tb/block_pair_splitter_test.sv
module block_pair_splitter_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [511:0] in_data = '0;
  logic         out0_valid, out1_valid;
  logic         out0_ready = 1'b0, out1_ready = 1'b0;
  logic [255:0] out0_data, out1_data;

  int tests = 0;
  int fails = 0;
  int pop0 = 0;
  int pop1 = 0;
  int rmode0 = 0;
  int rmode1 = 0;
  logic [255:0] q0 [$];
  logic [255:0] q1 [$];

  always #5 clk = ~clk;

  block_pair_splitter uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out0_valid(out0_valid), .out0_ready(out0_ready), .out0_data(out0_data),
    .out1_valid(out1_valid), .out1_ready(out1_ready), .out1_data(out1_data)
  );

  function automatic logic [511:0] mk(input int blk, input int beat);
    logic [511:0] w;
    for (int i = 0; i < 16; i++) w[i*32 +: 32] = {8'(blk), 8'(beat), 8'(i), 8'h5A};
    return w;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ready drivers, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    out0_ready = (rmode0 == 1) ? 1'b1 : (rmode0 == 2) ? 1'($urandom % 2) : 1'b0;
    out1_ready = (rmode1 == 1) ? 1'b1 : (rmode1 == 2) ? 1'($urandom % 2) : 1'b0;
  end

  // monitor: a handshake seen at the falling edge completes at the next rising edge
  always @(negedge clk) begin
    if (!rst) begin
      if (out0_valid && out0_ready) begin
        if (q0.size() == 0) chk("R3 side0 unexpected beat", out0_data, 'x);
        else chk("R3 side0 data", out0_data, q0.pop_front());
        pop0++;
      end
      if (out1_valid && out1_ready) begin
        if (q1.size() == 0) chk("R3 side1 unexpected beat", out1_data, 'x);
        else chk("R3 side1 data", out1_data, q1.pop_front());
        pop1++;
      end
    end
  end

  // driver: called and returns just after a rising edge
  task automatic send_beat(input int blk, input int beat);
    logic [511:0] w;
    w = mk(blk, beat);
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    if (blk % 2 == 0) begin q0.push_back(w[255:0]); q0.push_back(w[511:256]); end
    else              begin q1.push_back(w[255:0]); q1.push_back(w[511:256]); end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_block(input int blk);
    for (int b = 0; b < 64; b++) send_beat(blk, b);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [255:0] held;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 out0_valid after reset", 256'(out0_valid), 256'(0));
    chk("R1 out1_valid after reset", 256'(out1_valid), 256'(0));
    chk("R1 in_ready after reset", 256'(in_ready), 256'(1));
    @(posedge clk); #1;

    // R4: partial block gives no valid
    for (int b = 0; b < 63; b++) send_beat(0, b);
    idle(8);
    @(negedge clk);
    chk("R4 out0_valid after 63 beats", 256'(out0_valid), 256'(0));
    @(posedge clk); #1;
    send_beat(0, 63);
    idle(4);
    @(negedge clk);
    chk("R4 out0_valid after full block", 256'(out0_valid), 256'(1));
    chk("R2 block 0 not on side 1", 256'(out1_valid), 256'(0));
    chk("R3 first beat is low half", out0_data, mk(0, 0)[255:0]);
    held = out0_data;
    @(posedge clk); #1;
    idle(3);
    @(negedge clk);
    chk("R8 valid held under stall", 256'(out0_valid), 256'(1));
    chk("R8 data held under stall", out0_data, held);
    @(posedge clk); #1;

    // R5: fill both sides
    for (int k = 1; k < 8; k++) send_block(k);
    idle(4);
    @(negedge clk);
    chk("R5 in_ready low with four blocks per side", 256'(in_ready), 256'(0));
    chk("R2 block 1 on side 1", 256'(out1_valid), 256'(1));
    @(posedge clk); #1;

    // R7 and R5: drain side 1 only, side 0 stays full and next in turn
    rmode1 = 1;
    wait (pop1 == 512);
    idle(4);
    @(negedge clk);
    chk("R7 side1 drained while side0 stalled", 256'(pop1), 256'(512));
    chk("R7 side0 untouched", 256'(pop0), 256'(0));
    chk("R5 no skip to side 1", 256'(in_ready), 256'(0));
    @(posedge clk); #1;

    // R6: slot returns after the 128th accepted beat
    rmode0 = 1;
    wait (pop0 == 127);
    chk("R6 in_ready still low before 128th beat", 256'(in_ready), 256'(0));
    wait (pop0 == 128);
    @(posedge clk);
    @(negedge clk);
    chk("R6 in_ready after 128th beat", 256'(in_ready), 256'(1));
    @(posedge clk); #1;

    // mixed random readiness
    rmode0 = 2;
    rmode1 = 2;
    for (int k = 8; k < 20; k++) send_block(k);
    wait (q0.size() == 0 && q1.size() == 0);
    idle(6);
    @(negedge clk);
    chk("R2 side0 beat total", 256'(pop0), 256'(1280));
    chk("R2 side1 beat total", 256'(pop1), 256'(1280));
    chk("R4 side0 idle when empty", 256'(out0_valid), 256'(0));
    chk("R4 side1 idle when empty", 256'(out1_valid), 256'(0));
    finish_run();
  end

endmodule